// File: doc/BRIEF.md
# Processor Status Flags, Compare and Branch Unit

This block keeps the eight-bit processor status word of a small eight-bit core. It decides the flag effects of the compare and bit-test operations and resolves the eight conditional relative branches. Each cycle the issuing pipeline may present one operation on `op_sel_i` with `op_valid_i` high. Alongside it come the three working registers A, X and Y, an eight-bit operand, the branch opcode byte and the address of the instruction that follows.

Compare, bit-test, flag set and clear commands and register-load flag updates change the status word at the clock edge that accepts them. A branch leaves the flags alone. One cycle after the branch is accepted, the block reports whether the branch was taken and gives the resulting program counter.

A two-state machine times the branch report. `ST_READY` means no report is pending. `ST_REPORT` means the branch outputs are valid this cycle. The transition `BR_ACCEPT` goes from either state to `ST_REPORT` when a branch is accepted, so back-to-back branches stay in `ST_REPORT`. The transition `BR_DONE` goes to `ST_READY` on any other cycle.

Top module: `sfcb_unit`

## Requirements
- R1: During and right after reset the status word reads 0x34 (bit positions 7..0 = N, V, 1, B, D, I, Z, C) and `br_valid_o` is 0.
- R2: Compare codes 1, 2 and 3 compare A, X or Y against the operand. C is set when the register is greater than or equal to the operand (unsigned), Z is set when they are equal, and N takes bit 7 of the 8-bit difference. B, D, I and V are unchanged.
- R3: Bit test (code 4) sets N from operand bit 7, V from operand bit 6, and Z when A AND operand is zero. C, D and I are kept.
- R4: A branch (code 5) uses the opcode byte. Bits 7:6 select the flag (00 N, 01 V, 10 C, 11 Z) and bit 5 gives the required flag value. The branch is taken only when bits 4:0 are 10000 and the selected flag equals bit 5. A branch never changes the status word.
- R5: A taken branch gives a target equal to the next-instruction address plus the sign-extended operand, modulo 65536. A branch that is not taken gives the next-instruction address.
- R6: Codes 6 to 12 set C, clear C, set D, clear D, set I, clear I and clear V. No other flag changes.
- R7: Code 13 (register load) sets N from operand bit 7 and Z when the operand is zero. Code 14 (X to stack pointer), code 0 and code 15 leave the status word unchanged.
- R8: Status bit 5 always reads 1, and bit B keeps its reset value.
- R9: `br_valid_o` is high in exactly the cycle after a branch is accepted, including back-to-back branches. It is low after any other cycle.
- R10: With `op_valid_i` low the status word does not change.
- R11: A branch opcode whose bits 4:0 are not 10000 is reported as not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid_i | input | 1 | Operation present this cycle |
| op_sel_i | input | 4 | Operation code (see R2 to R7) |
| opcode_i | input | 8 | Branch opcode byte |
| a_i | input | 8 | Register A |
| x_i | input | 8 | Register X |
| y_i | input | 8 | Register Y |
| operand_i | input | 8 | Operand, branch offset or loaded value |
| next_pc_i | input | 16 | Address of the following instruction |
| status_o | output | 8 | Status word N,V,1,B,D,I,Z,C |
| br_valid_o | output | 1 | Branch report valid |
| br_taken_o | output | 1 | Branch taken |
| br_target_o | output | 16 | Resulting program counter |

## Verification
Every result of this block is due exactly one clock edge after the operation is presented. The status word changes at the accepting edge. The branch report is valid for the single following cycle. The bench drives each operation on a falling edge and checks status, report-valid, taken and target on the next falling edge. This puts every check after exactly one register stage, and a missing report or a stale report both show up.

// File: rtl/sfcb_pkg.sv
package sfcb_pkg;

    typedef enum logic [3:0] {
        OP_NOP      = 4'd0,
        OP_CMP_A    = 4'd1,
        OP_CMP_X    = 4'd2,
        OP_CMP_Y    = 4'd3,
        OP_BIT_TEST = 4'd4,
        OP_BRANCH   = 4'd5,
        OP_SET_C    = 4'd6,
        OP_CLR_C    = 4'd7,
        OP_SET_D    = 4'd8,
        OP_CLR_D    = 4'd9,
        OP_SET_I    = 4'd10,
        OP_CLR_I    = 4'd11,
        OP_CLR_V    = 4'd12,
        OP_LOAD_NZ  = 4'd13,
        OP_XFER_SP  = 4'd14,
        OP_RSVD     = 4'd15
    } sfcb_op_e;

    typedef enum logic {
        ST_READY  = 1'b0,
        ST_REPORT = 1'b1
    } sfcb_state_e;

    localparam int unsigned STAT_W = 8;
    localparam int unsigned FL_C = 0;
    localparam int unsigned FL_Z = 1;
    localparam int unsigned FL_I = 2;
    localparam int unsigned FL_D = 3;
    localparam int unsigned FL_B = 4;
    localparam int unsigned FL_U = 5;
    localparam int unsigned FL_V = 6;
    localparam int unsigned FL_N = 7;

    // branch opcode flag select (bits 7:6)
    localparam logic [1:0] BSEL_N = 2'b00;
    localparam logic [1:0] BSEL_V = 2'b01;
    localparam logic [1:0] BSEL_C = 2'b10;
    localparam logic [1:0] BSEL_Z = 2'b11;
    localparam logic [4:0] BR_LOW_PATTERN = 5'b10000;

endpackage

// File: rtl/sfcb_compare.sv
module sfcb_compare #(
    parameter int unsigned DATA_W = 8
) (
    input  logic [1:0]        reg_sel_i,   // 0:A 1:X 2:Y
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] x_i,
    input  logic [DATA_W-1:0] y_i,
    input  logic [DATA_W-1:0] operand_i,
    output logic              cmp_n_o,
    output logic              cmp_z_o,
    output logic              cmp_c_o,
    output logic              bt_n_o,
    output logic              bt_v_o,
    output logic              bt_z_o
);
    localparam int unsigned MSB = DATA_W - 1;

    logic [DATA_W-1:0] lhs;
    logic [DATA_W-1:0] diff;

    always_comb begin
        unique case (reg_sel_i)
            2'd1:    lhs = x_i;
            2'd2:    lhs = y_i;
            default: lhs = a_i;
        endcase
    end

    assign diff    = lhs - operand_i;
    assign cmp_c_o = (lhs >= operand_i);
    assign cmp_z_o = (diff == '0);
    assign cmp_n_o = diff[MSB];

    assign bt_n_o  = operand_i[MSB];
    assign bt_v_o  = operand_i[MSB-1];
    assign bt_z_o  = ((a_i & operand_i) == '0);

endmodule

// File: rtl/sfcb_branch.sv
module sfcb_branch #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned PC_W   = 16
) (
    input  logic [7:0]        opcode_i,
    input  logic              flag_n_i,
    input  logic              flag_v_i,
    input  logic              flag_c_i,
    input  logic              flag_z_i,
    input  logic [DATA_W-1:0] offset_i,
    input  logic [PC_W-1:0]   next_pc_i,
    output logic              taken_o,
    output logic [PC_W-1:0]   target_o
);
    import sfcb_pkg::*;

    localparam int unsigned EXT_W = PC_W - DATA_W;

    logic            sel_flag;
    logic            well_formed;
    logic [PC_W-1:0] offset_ext;

    always_comb begin
        unique case (opcode_i[7:6])
            BSEL_N:  sel_flag = flag_n_i;
            BSEL_V:  sel_flag = flag_v_i;
            BSEL_C:  sel_flag = flag_c_i;
            default: sel_flag = flag_z_i;
        endcase
    end

    assign well_formed = (opcode_i[4:0] == BR_LOW_PATTERN);
    assign taken_o     = well_formed && (sel_flag == opcode_i[5]);
    assign offset_ext  = {{EXT_W{offset_i[DATA_W-1]}}, offset_i};
    assign target_o    = taken_o ? (next_pc_i + offset_ext) : next_pc_i;

endmodule

// File: rtl/sfcb_unit.sv
module sfcb_unit #(
    parameter int unsigned DATA_W       = 8,
    parameter int unsigned PC_W         = 16,
    parameter logic [7:0]  RESET_STATUS = 8'h34
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid_i,
    input  logic [3:0]        op_sel_i,
    input  logic [7:0]        opcode_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] x_i,
    input  logic [DATA_W-1:0] y_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic [PC_W-1:0]   next_pc_i,
    output logic [7:0]        status_o,
    output logic              br_valid_o,
    output logic              br_taken_o,
    output logic [PC_W-1:0]   br_target_o
);
    import sfcb_pkg::*;

    localparam int unsigned MSB = DATA_W - 1;

    sfcb_op_e    op;
    sfcb_state_e state_q, state_d;
    logic [7:0]  status_q, status_d;
    logic [1:0]  reg_sel;
    logic        cmp_n, cmp_z, cmp_c, bt_n, bt_v, bt_z;
    logic        br_taken;
    logic [PC_W-1:0] br_target;
    logic        br_accept;

    assign op = sfcb_op_e'(op_sel_i);

    always_comb begin
        unique case (op)
            OP_CMP_X: reg_sel = 2'd1;
            OP_CMP_Y: reg_sel = 2'd2;
            default:  reg_sel = 2'd0;
        endcase
    end

    sfcb_compare #(.DATA_W(DATA_W)) u_compare (
        .reg_sel_i (reg_sel),
        .a_i       (a_i),
        .x_i       (x_i),
        .y_i       (y_i),
        .operand_i (operand_i),
        .cmp_n_o   (cmp_n),
        .cmp_z_o   (cmp_z),
        .cmp_c_o   (cmp_c),
        .bt_n_o    (bt_n),
        .bt_v_o    (bt_v),
        .bt_z_o    (bt_z)
    );

    sfcb_branch #(.DATA_W(DATA_W), .PC_W(PC_W)) u_branch (
        .opcode_i  (opcode_i),
        .flag_n_i  (status_q[FL_N]),
        .flag_v_i  (status_q[FL_V]),
        .flag_c_i  (status_q[FL_C]),
        .flag_z_i  (status_q[FL_Z]),
        .offset_i  (operand_i),
        .next_pc_i (next_pc_i),
        .taken_o   (br_taken),
        .target_o  (br_target)
    );

    // next status word
    always_comb begin
        status_d = status_q;
        if (op_valid_i) begin
            unique case (op)
                OP_CMP_A, OP_CMP_X, OP_CMP_Y: begin
                    status_d[FL_N] = cmp_n;
                    status_d[FL_Z] = cmp_z;
                    status_d[FL_C] = cmp_c;
                end
                OP_BIT_TEST: begin
                    status_d[FL_N] = bt_n;
                    status_d[FL_V] = bt_v;
                    status_d[FL_Z] = bt_z;
                end
                OP_SET_C:   status_d[FL_C] = 1'b1;
                OP_CLR_C:   status_d[FL_C] = 1'b0;
                OP_SET_D:   status_d[FL_D] = 1'b1;
                OP_CLR_D:   status_d[FL_D] = 1'b0;
                OP_SET_I:   status_d[FL_I] = 1'b1;
                OP_CLR_I:   status_d[FL_I] = 1'b0;
                OP_CLR_V:   status_d[FL_V] = 1'b0;
                OP_LOAD_NZ: begin
                    status_d[FL_N] = operand_i[MSB];
                    status_d[FL_Z] = (operand_i == '0);
                end
                OP_NOP, OP_BRANCH, OP_XFER_SP, OP_RSVD: status_d = status_q;
                default:    status_d = status_q;
            endcase
        end
        status_d[FL_U] = 1'b1;
    end

    // state transitions: BR_ACCEPT -> ST_REPORT, BR_DONE -> ST_READY
    assign br_accept = op_valid_i && (op == OP_BRANCH);

    always_comb begin
        unique case (state_q)
            ST_READY:  state_d = br_accept ? ST_REPORT : ST_READY;
            ST_REPORT: state_d = br_accept ? ST_REPORT : ST_READY;
            default:   state_d = ST_READY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q    <= RESET_STATUS | 8'h20;
            br_taken_o  <= 1'b0;
            br_target_o <= '0;
        end else begin
            status_q <= status_d;
            if (br_accept) begin
                br_taken_o  <= br_taken;
                br_target_o <= br_target;
            end
        end
    end

    assign status_o   = status_q;
    assign br_valid_o = (state_q == ST_REPORT);

endmodule

// File: rtl/sfcb_unit_chk.sv
module sfcb_unit_chk #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned PC_W   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid_i,
    input logic [3:0]        op_sel_i,
    input logic [DATA_W-1:0] a_i,
    input logic [DATA_W-1:0] operand_i,
    input logic [PC_W-1:0]   next_pc_i,
    input logic [7:0]        status_o,
    input logic              br_valid_o,
    input logic              br_taken_o,
    input logic [PC_W-1:0]   br_target_o
);
    AST_UNUSED_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[5] == 1'b1); // R8

    AST_REPORT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_sel_i == 4'd5) |=> br_valid_o); // R9

    AST_NO_STRAY_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid_i && op_sel_i == 4'd5) |=> !br_valid_o); // R9

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid_i |=> $stable(status_o)); // R10

    AST_BRANCH_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_sel_i == 4'd5) |=> $stable(status_o)); // R4

    AST_CMP_A_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_sel_i == 4'd1) |=> status_o[0] == ($past(a_i) >= $past(operand_i))); // R2

    AST_NOT_TAKEN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid_o && !br_taken_o) |-> br_target_o == $past(next_pc_i)); // R5

endmodule

bind sfcb_unit sfcb_unit_chk #(.DATA_W(DATA_W), .PC_W(PC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid_i  (op_valid_i),
    .op_sel_i    (op_sel_i),
    .a_i         (a_i),
    .operand_i   (operand_i),
    .next_pc_i   (next_pc_i),
    .status_o    (status_o),
    .br_valid_o  (br_valid_o),
    .br_taken_o  (br_taken_o),
    .br_target_o (br_target_o)
);

// File: tb/sfcb_unit_bench.sv
`timescale 1ns/1ps
module sfcb_unit_bench;

    typedef struct packed {
        logic        vld;
        logic [3:0]  op;
        logic [7:0]  code;
        logic [7:0]  a;
        logic [7:0]  x;
        logic [7:0]  y;
        logic [7:0]  opnd;
        logic [15:0] npc;
        logic [7:0]  exp_st;
        logic        exp_bv;
        logic        exp_tk;
        logic [15:0] exp_tgt;
    } vec_t;

    localparam int NV = 30;
    // vld op code a x y opnd npc | status bv tk target
    localparam vec_t VECS [NV] = '{
        '{1'b1, 4'd6,  8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0000, 8'h35, 1'b0, 1'b0, 16'h0000}, // R6 set C
        '{1'b1, 4'd1,  8'h00, 8'h40, 8'h00, 8'h00, 8'h40, 16'h0000, 8'h37, 1'b0, 1'b0, 16'h0000}, // R2 A==op
        '{1'b1, 4'd2,  8'h00, 8'h00, 8'h10, 8'h00, 8'h20, 16'h0000, 8'hB4, 1'b0, 1'b0, 16'h0000}, // R2 X<op
        '{1'b1, 4'd3,  8'h00, 8'h00, 8'h00, 8'hFF, 8'h01, 16'h0000, 8'hB5, 1'b0, 1'b0, 16'h0000}, // R2 Y>op
        '{1'b1, 4'd4,  8'h00, 8'h0F, 8'h00, 8'h00, 8'hC0, 16'h0000, 8'hF7, 1'b0, 1'b0, 16'h0000}, // R3
        '{1'b1, 4'd4,  8'h00, 8'h01, 8'h00, 8'h00, 8'h01, 16'h0000, 8'h35, 1'b0, 1'b0, 16'h0000}, // R3
        '{1'b1, 4'd5,  8'hB0, 8'h00, 8'h00, 8'h00, 8'h10, 16'h1000, 8'h35, 1'b1, 1'b1, 16'h1010}, // R4 C set
        '{1'b1, 4'd5,  8'h90, 8'h00, 8'h00, 8'h00, 8'h10, 16'h2000, 8'h35, 1'b1, 1'b0, 16'h2000}, // R9 back-to-back
        '{1'b1, 4'd7,  8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0000, 8'h34, 1'b0, 1'b0, 16'h0000}, // R6 clr C
        '{1'b1, 4'd8,  8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0000, 8'h3C, 1'b0, 1'b0, 16'h0000}, // R6 set D
        '{1'b1, 4'd11, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0000, 8'h38, 1'b0, 1'b0, 16'h0000}, // R6 clr I
        '{1'b1, 4'd13, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0000, 8'h3A, 1'b0, 1'b0, 16'h0000}, // R7 load zero
        '{1'b1, 4'd5,  8'hF0, 8'h00, 8'h00, 8'h00, 8'hFE, 16'h0001, 8'h3A, 1'b1, 1'b1, 16'hFFFF}, // R5 wrap down
        '{1'b1, 4'd13, 8'h00, 8'h00, 8'h00, 8'h00, 8'h80, 16'h0000, 8'hB8, 1'b0, 1'b0, 16'h0000}, // R7 load neg
        '{1'b1, 4'd5,  8'h30, 8'h00, 8'h00, 8'h00, 8'h7F, 16'hFFF0, 8'hB8, 1'b1, 1'b1, 16'h006F}, // R5 wrap up
        '{1'b1, 4'd4,  8'h00, 8'hFF, 8'h00, 8'h00, 8'h40, 16'h0000, 8'h78, 1'b0, 1'b0, 16'h0000}, // R3 V only
        '{1'b1, 4'd5,  8'h70, 8'h00, 8'h00, 8'h00, 8'h80, 16'h0100, 8'h78, 1'b1, 1'b1, 16'h0080}, // R4 V set
        '{1'b1, 4'd5,  8'h50, 8'h00, 8'h00, 8'h00, 8'h20, 16'h0300, 8'h78, 1'b1, 1'b0, 16'h0300}, // R4 V clear nt
        '{1'b1, 4'd12, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0000, 8'h38, 1'b0, 1'b0, 16'h0000}, // R6 clr V
        '{1'b1, 4'd14, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0000, 8'h38, 1'b0, 1'b0, 16'h0000}, // R7 xfer SP
        '{1'b1, 4'd5,  8'hD0, 8'h00, 8'h00, 8'h00, 8'h05, 16'h0400, 8'h38, 1'b1, 1'b1, 16'h0405}, // R4 Z clear
        '{1'b1, 4'd5,  8'h10, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0500, 8'h38, 1'b1, 1'b1, 16'h0500}, // R4 N clear
        '{1'b1, 4'd10, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0000, 8'h3C, 1'b0, 1'b0, 16'h0000}, // R6 set I
        '{1'b1, 4'd9,  8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0000, 8'h34, 1'b0, 1'b0, 16'h0000}, // R6 clr D
        '{1'b1, 4'd5,  8'h91, 8'h00, 8'h00, 8'h00, 8'h10, 16'h0600, 8'h34, 1'b1, 1'b0, 16'h0600}, // R11 bad code
        '{1'b1, 4'd15, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0000, 8'h34, 1'b0, 1'b0, 16'h0000}, // R7 reserved
        '{1'b0, 4'd6,  8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0000, 8'h34, 1'b0, 1'b0, 16'h0000}, // R10 idle
        '{1'b0, 4'd5,  8'h90, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0000, 8'h34, 1'b0, 1'b0, 16'h0000}, // R10 idle branch
        '{1'b1, 4'd0,  8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0000, 8'h34, 1'b0, 1'b0, 16'h0000}, // R7 nop
        '{1'b1, 4'd1,  8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 16'h0000, 8'hB4, 1'b0, 1'b0, 16'h0000}  // R2 0<1
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid_i = 1'b0;
    logic [3:0]  op_sel_i = '0;
    logic [7:0]  opcode_i = '0;
    logic [7:0]  a_i = '0, x_i = '0, y_i = '0, operand_i = '0;
    logic [15:0] next_pc_i = '0;
    logic [7:0]  status_o;
    logic        br_valid_o, br_taken_o;
    logic [15:0] br_target_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    sfcb_unit u_sfcb_unit (
        .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .op_sel_i(op_sel_i),
        .opcode_i(opcode_i), .a_i(a_i), .x_i(x_i), .y_i(y_i),
        .operand_i(operand_i), .next_pc_i(next_pc_i), .status_o(status_o),
        .br_valid_o(br_valid_o), .br_taken_o(br_taken_o), .br_target_o(br_target_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        op_valid_i = v.vld; op_sel_i = v.op; opcode_i = v.code;
        a_i = v.a; x_i = v.x; y_i = v.y; operand_i = v.opnd; next_pc_i = v.npc;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset status", status_o, 8'h34);
        check("R1 reset br_valid", br_valid_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 status after release", status_o, 8'h34);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            check($sformatf("R2-vector %0d status", i), status_o, VECS[i].exp_st);
            check($sformatf("R9 vector %0d br_valid", i), br_valid_o, VECS[i].exp_bv);
            if (VECS[i].exp_bv) begin
                check($sformatf("R4 vector %0d taken", i), br_taken_o, VECS[i].exp_tk);
                check($sformatf("R5 vector %0d target", i), br_target_o, VECS[i].exp_tgt);
            end
        end

        // R8: bit 5 and B hold after a sequence that clears everything clearable
        op_valid_i = 1'b1; op_sel_i = 4'd13; operand_i = 8'h01;
        @(negedge clk);
        op_sel_i = 4'd7;
        @(negedge clk);
        op_valid_i = 1'b0;
        check("R8 bit5 forced", status_o[5], 1'b1);
        check("R8 B kept", status_o[4], 1'b1);

        // R9: report drops after the single cycle
        op_valid_i = 1'b1; op_sel_i = 4'd5; opcode_i = 8'h90; operand_i = 8'h02; next_pc_i = 16'h0010;
        @(negedge clk);
        op_valid_i = 1'b0;
        check("R9 report high", br_valid_o, 1'b1);
        check("R5 forward target", br_target_o, 16'h0012);
        @(negedge clk);
        check("R9 report dropped", br_valid_o, 1'b0);

        // R1: reset in mid-run restores status
        op_valid_i = 1'b1; op_sel_i = 4'd8;
        @(negedge clk);
        op_sel_i = 4'd5;
        rst_n = 1'b0;
        @(negedge clk);
        op_valid_i = 1'b0;
        check("R1 mid-run reset status", status_o, 8'h34);
        check("R1 mid-run reset br_valid", br_valid_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule